// File: doc/BRIEF.md
# Masked burst address counter

This block generates the access address for one port of a synchronous memory. It holds three registers of the same width. The counter supplies the address. The mask limits which counter bits may move. The mirror remembers the last value written into the counter. Commands are sampled on the rising clock edge and can load the counter, load the mask, clear either of them, or advance the counter. A load strobe carries both load commands, and a select input picks the target.

The mask splits the counter into a frozen upper region and a counting lower region. If mask bit 0 is clear, the counter advances by two. When an advance would carry out of the counting region, the counter is reloaded from the mirror. A burst can therefore be replayed from its start address without a new load. An active-low wrap flag is low while every counting bit is one, so it warns one step before the replay happens. An active-low master reset, asynchronous to the clock, sets all three registers to known values.

Top module: `masked_burst_counter`

## Requirements
- R1: While `rst_n` is low, asynchronously to `clk`, `addr_out` is zero, the mask is all ones and `wrap_irq_n` is high. After release, an advance from 0x00FF gives 0x0100.
- R2: During an advance that does not wrap, and during a counter clear, counter bits whose mask bit is 0 keep their value.
- R3: With mask bit 0 at 0 and a contiguous run of ones above it, each advance adds two within the counting region and leaves bit 0 unchanged.
- R4: With no command active, or with only a mask command active, the counter holds. The mask changes only on a mask load or a mask clear.
- R5: The mirror changes only on a counter load or a counter clear, and then takes the counter's new value.
- R6: An advance taken while every counting bit (mask bit 1) is one loads the counter from the mirror.
- R7: Command priority from highest to lowest: `clr_cnt`, `clr_mask`, counter load, mask load, `cnt_en`.
- R8: `clr_cnt` clears only the counter bits whose mask bit is 1, and writes the same value into the mirror.
- R9: `wrap_irq_n` is 0 exactly while every counter bit whose mask bit is 1 is also 1.
- R10: `load_strobe` with `mask_sel`=0 loads `addr_in` into the counter. `load_strobe` with `mask_sel`=1 loads `addr_in` into the mask. `clr_mask` sets the mask to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| clr_cnt | input | 1 | Clear the counting bits of the counter and the mirror |
| clr_mask | input | 1 | Set the mask to all ones |
| load_strobe | input | 1 | Load `addr_in` into the register chosen by `mask_sel` |
| mask_sel | input | 1 | 0: load targets the counter; 1: load targets the mask |
| cnt_en | input | 1 | Advance the counter |
| addr_in | input | AW | Load value |
| addr_out | output | AW | Current counter value |
| wrap_irq_n | output | 1 | Low while all counting bits are one |

## Verification
The hardest situation to reach is a replay under a step-by-two mask. In that case the mirror differs from the counter in a frozen bit. To get there, the stimulus first clears the counter under a four-bit mask. It then loads a mask with bit 0 clear and advances until the counting bits fill and wrap. The vector table then switches the mask at the full-count boundaries and drives several commands at once, which checks the priority order.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
   typedef enum logic [2:0] {
      OP_HOLD,
      OP_CNT_CLR,
      OP_MASK_CLR,
      OP_CNT_LOAD,
      OP_MASK_LOAD,
      OP_STEP
   } mbc_op_e;
endpackage

// File: rtl/mbc_cmd_decode.sv
module mbc_cmd_decode
   import mbc_pkg::*;
(
   input  logic    clr_cnt,
   input  logic    clr_mask,
   input  logic    load_strobe,
   input  logic    mask_sel,
   input  logic    cnt_en,
   output mbc_op_e op
);
   // Fixed priority chain: clears first, loads next, advance last.
   always_comb begin
      if (clr_cnt)                      op = OP_CNT_CLR;
      else if (clr_mask)                op = OP_MASK_CLR;
      else if (load_strobe && !mask_sel) op = OP_CNT_LOAD;
      else if (load_strobe)             op = OP_MASK_LOAD;
      else if (cnt_en)                  op = OP_STEP;
      else                              op = OP_HOLD;
   end
endmodule

// File: rtl/mbc_mask_reg.sv
module mbc_mask_reg
   import mbc_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mbc_op_e       op,
   input  logic [AW-1:0] din,
   output logic [AW-1:0] mask
);
   logic [AW-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask_q <= '1;
      else if (op == OP_MASK_CLR)  mask_q <= '1;
      else if (op == OP_MASK_LOAD) mask_q <= din;
   end

   assign mask = mask_q;

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_MASK_CLR && op != OP_MASK_LOAD) |=> $stable(mask_q)); // R4
endmodule

// File: rtl/mbc_count_core.sv
module mbc_count_core
   import mbc_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mbc_op_e       op,
   input  logic [AW-1:0] din,
   input  logic [AW-1:0] mask,
   output logic [AW-1:0] cnt,
   output logic          full
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] cnt_q, mir_q, cnt_d, mir_d;
   logic [AW-1:0] filled, bumped, stepped;

   // Frozen bits are forced to one so a carry ripples through a frozen bit 0.
   assign filled = cnt_q | ~mask;
   assign bumped = filled + ONE;

   generate
      for (genvar i = 0; i < AW; i++) begin : g_merge
         assign stepped[i] = mask[i] ? bumped[i] : cnt_q[i];
      end
   endgenerate

   assign full = ((cnt_q & mask) == mask);

   always_comb begin
      cnt_d = cnt_q;
      mir_d = mir_q;
      unique case (op)
         OP_CNT_CLR: begin
            cnt_d = cnt_q & ~mask;
            mir_d = cnt_q & ~mask;
         end
         OP_CNT_LOAD: begin
            cnt_d = din;
            mir_d = din;
         end
         OP_STEP:  cnt_d = full ? mir_q : stepped;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mir_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         mir_q <= mir_d;
      end
   end

   assign cnt = cnt_q;

   AST_FROZEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_STEP && !full) || op == OP_CNT_CLR)
         |=> (((cnt_q ^ $past(cnt_q)) & ~$past(mask)) == '0)); // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op inside {OP_HOLD, OP_MASK_CLR, OP_MASK_LOAD}) |=> $stable(cnt_q)); // R4
   AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op inside {OP_HOLD, OP_MASK_CLR, OP_MASK_LOAD, OP_STEP}) |=> $stable(mir_q)); // R5
   AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_STEP && full) |=> (cnt_q == $past(mir_q))); // R6
   AST_LOAD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CNT_LOAD) |=> (cnt_q == mir_q)); // R5
endmodule

// File: rtl/masked_burst_counter.sv
module masked_burst_counter
   import mbc_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_cnt,
   input  logic          clr_mask,
   input  logic          load_strobe,
   input  logic          mask_sel,
   input  logic          cnt_en,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out,
   output logic          wrap_irq_n
);
   generate
      if (AW < 15 || AW > 18) begin : g_bad_width
         $error("masked_burst_counter: AW must lie in 15..18");
      end
   endgenerate

   mbc_op_e       op;
   logic [AW-1:0] mask;
   logic          full;

   mbc_cmd_decode u_dec (
      .clr_cnt     (clr_cnt),
      .clr_mask    (clr_mask),
      .load_strobe (load_strobe),
      .mask_sel    (mask_sel),
      .cnt_en      (cnt_en),
      .op          (op)
   );

   mbc_mask_reg #(.AW(AW)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .din   (addr_in),
      .mask  (mask)
   );

   mbc_count_core #(.AW(AW)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .din   (addr_in),
      .mask  (mask),
      .cnt   (addr_out),
      .full  (full)
   );

   assign wrap_irq_n = ~full;

   AST_IRQ_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask && !clr_cnt) |=> (wrap_irq_n == (addr_out != '1))); // R9
endmodule

// File: tb/tb_masked_burst_counter.sv
`timescale 1ns/1ps
module tb_masked_burst_counter;
   localparam int AW = 16;
   localparam int NV = 32;

   typedef struct packed {
      logic          cc;
      logic          cm;
      logic          st;
      logic          md;
      logic          ce;
      logic [AW-1:0] din;
      logic [AW-1:0] exp_a;
      logic          exp_i;
      logic [3:0]    req;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h1234,16'h1234,1'b1,4'd10}, // R10 counter load
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1235,1'b1,4'd1},  // R1 full-width advance
      '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h000F,16'h1235,1'b1,4'd10}, // R10 mask load
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1236,1'b1,4'd2},  // R2
      '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h123E,16'h123E,1'b1,4'd5},  // R5 mirror load
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h123F,1'b0,4'd9},  // R9 full
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h123E,1'b1,4'd6},  // R6 wrap
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h123F,1'b0,4'd9},  // R9
      '{1'b0,1'b0,1'b0,1'b0,1'b0,16'hAAAA,16'h123F,1'b0,4'd4},  // R4 idle hold
      '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h1230,1'b1,4'd8},  // R8 partial clear
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1231,1'b1,4'd2},  // R2
      '{1'b0,1'b0,1'b1,1'b1,1'b0,16'h000E,16'h1231,1'b1,4'd4},  // R4 mask load holds count
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1233,1'b1,4'd3},  // R3 step by two
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1235,1'b1,4'd3},  // R3
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1237,1'b1,4'd3},  // R3
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1239,1'b1,4'd3},  // R3
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h123B,1'b1,4'd3},  // R3
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h123D,1'b1,4'd3},  // R3
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h123F,1'b0,4'd9},  // R9 bit 0 ignored
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1230,1'b1,4'd6},  // R6 wrap to cleared mirror
      '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h1230,1'b1,4'd7},  // R7 mask clear over advance
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h1231,1'b1,4'd10}, // R10 mask back to all ones
      '{1'b1,1'b0,1'b1,1'b0,1'b1,16'hABCD,16'h0000,1'b1,4'd7},  // R7 clear over load
      '{1'b0,1'b0,1'b1,1'b0,1'b1,16'hFFFE,16'hFFFE,1'b1,4'd7},  // R7 load over advance
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'hFFFF,1'b0,4'd9},  // R9
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'hFFFE,1'b1,4'd6},  // R6
      '{1'b0,1'b1,1'b1,1'b0,1'b0,16'h0000,16'hFFFE,1'b1,4'd7},  // R7 mask clear over load
      '{1'b0,1'b0,1'b1,1'b1,1'b1,16'h00FF,16'hFFFE,1'b1,4'd7},  // R7 mask load over advance
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'hFFFF,1'b0,4'd9},  // R9
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'hFFFE,1'b1,4'd6},  // R6
      '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,1'b1,4'd10}, // R10
      '{1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0001,1'b1,4'd2}   // R2
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_cnt = 1'b0, clr_mask = 1'b0, load_strobe = 1'b0;
   logic          mask_sel = 1'b0, cnt_en = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic          wrap_irq_n;
   int            applied = 0;
   int            miscompares = 0;

   always #10 clk = ~clk;

   masked_burst_counter #(.AW(AW)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_cnt     (clr_cnt),
      .clr_mask    (clr_mask),
      .load_strobe (load_strobe),
      .mask_sel    (mask_sel),
      .cnt_en      (cnt_en),
      .addr_in     (addr_in),
      .addr_out    (addr_out),
      .wrap_irq_n  (wrap_irq_n)
   );

   task automatic check(input int req, input logic [AW-1:0] ea, input logic ei);
      applied++;
      if (addr_out !== ea || wrap_irq_n !== ei) begin
         miscompares++;
         $display("FAIL R%0d: addr=%h irq_n=%b expected addr=%h irq_n=%b",
                  req, addr_out, wrap_irq_n, ea, ei);
      end
   endtask

   task automatic apply(input logic cc, cm, st, md, ce, input logic [AW-1:0] d);
      clr_cnt = cc; clr_mask = cm; load_strobe = st; mask_sel = md; cnt_en = ce;
      addr_in = d;
      @(posedge clk);
      #2;
      clr_cnt = 1'b0; clr_mask = 1'b0; load_strobe = 1'b0; mask_sel = 1'b0;
      cnt_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      check(1, '0, 1'b1);                       // R1 state during reset
      rst_n = 1'b1;
      @(negedge clk);
      check(1, '0, 1'b1);                       // R1 state after release

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].cc, VEC[i].cm, VEC[i].st, VEC[i].md, VEC[i].ce, VEC[i].din);
         check(int'(VEC[i].req), VEC[i].exp_a, VEC[i].exp_i);
      end

      // R1: asynchronous reset mid-cycle, then the mask must be all ones again
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check(1, '0, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h00FF);
      check(1, 16'h00FF, 1'b1);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
      check(1, 16'h0100, 1'b1);                 // R1 carry past bit 7

      // R9 full at the top of an unmasked range, R6 wrap to mirror 0xFFFF
      apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF);
      check(9, 16'hFFFF, 1'b0);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
      check(6, 16'hFFFF, 1'b0);

      // R8 clear under a full mask zeroes everything and the mirror
      apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
      check(8, 16'h0000, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end
endmodule